// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer

This block is the digital control core of one synchronous buck phase. It accepts a PWM command that an analog front end has already sorted into a low, high or mid-level band, plus a stage enable (active low), a diode-emulation select, an undervoltage lockout flag, one comparator flag per gate that reports when that gate has fallen below its turn-off level, and a zero-crossing flag for the inductor current. It produces the enables for the high-side and low-side gate drivers and a fault flag.

Dead time is not a fixed delay. Whenever the command changes, the conducting gate is dropped first. The other gate is only enabled once the comparator reports that the first gate has actually discharged. A watchdog bounds that wait. A mid-level command that persists for a hold-off period parks the stage with both gates off. When diode emulation is enabled, the low-side gate is cut when the inductor current crosses zero.

Top module: `hbg_gate_ctrl`

## Requirements
- R1: With `pwm_lvl` = 2'b01 (high), the low-side enable is dropped first. The high-side enable rises one clock after a cycle in which `ls_below` was 1, and never while `ls_below` is 0.
- R2: With `pwm_lvl` = 2'b00 (low), the high-side enable is dropped first. The low-side enable rises one clock after a cycle in which `hs_below` was 1, and never while `hs_below` is 0.
- R3: `hs_on` and `ls_on` are never 1 together, for any input sequence.
- R4: `pwm_lvl` with bit 1 set is the mid band. A mid band held for HOLD_CYC (default 8) consecutive clock edges turns both gates off after that edge. A shorter excursion leaves the gates as they were. The count restarts whenever the band is left.
- R5: While `dis_n` is 0, both enables are 0 in the same cycle. A floating pin is expected to resolve to 0, so the stage is disabled by default.
- R6: With `skip_sel` = 0, a `zc` pulse while the low side conducts and the command is low turns the low side off at the next edge. It stays off until the command goes high.
- R7: With `skip_sel` = 1 (the level a floating pin resolves to), `zc` has no effect.
- R8: While `uvlo` is 1, both enables are 0 in the same cycle, including the cycle in which `uvlo` first rises between clock edges.
- R9: After a disable, a lockout or a tristate park, the stage sits all-off. It restarts only on the next high or low command, through the normal interlocked sequence. A mid command keeps it idle.
- R10: If the discharge flag awaited in a wait does not arrive within WD_CYC cycles (default 16), `fault` rises at edge WD_CYC+1 after the wait began, with both gates off. `fault` then holds until a disable, a lockout or a tristate park.
- R11: During and right after reset, `hs_on`, `ls_on` and `fault` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_lvl | input | 2 | Resolved PWM band: 00 low, 01 high, 1x mid |
| dis_n | input | 1 | Active-low stage disable |
| skip_sel | input | 1 | 0 enables diode emulation |
| uvlo | input | 1 | Undervoltage lockout active |
| hs_below | input | 1 | High-side gate below turn-off threshold |
| ls_below | input | 1 | Low-side gate below turn-off threshold |
| zc | input | 1 | Inductor current zero crossing |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |
| fault | output | 1 | Dead-time watchdog fault |

## Verification
The bench holds the discharge flags low across a command change. This catches a design that enables the incoming gate on a timer or on the command alone, because such a design would switch while the other gate is still charged. It holds the mid band for exactly one edge short of the hold-off and then for the full count, which exposes an off-by-one counter that parks too early or too late. It raises `uvlo` between edges, which catches enables that are only registered. It checks the watchdog one edge before and at its expiry. A random phase also watches for both enables high at once.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HS_WAIT = 3'd1,
    ST_HS_ON   = 3'd2,
    ST_LS_WAIT = 3'd3,
    ST_LS_ON   = 3'd4,
    ST_LS_SKIP = 3'd5,
    ST_FAULT   = 3'd6
  } seq_st_e;

  // band decode of the resolved PWM input
  function automatic logic lvl_mid(input logic [1:0] lvl);
    return lvl[1];
  endfunction

  function automatic logic lvl_high(input logic [1:0] lvl);
    return lvl == 2'b01;
  endfunction

  function automatic logic lvl_low(input logic [1:0] lvl);
    return lvl == 2'b00;
  endfunction

  // saturating increment used by both counters
  function automatic int unsigned sat_step(input int unsigned v, input int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // true on the last cycle of a window of lim cycles
  function automatic logic win_last(input int unsigned v, input int unsigned lim);
    return (v + 1) >= lim;
  endfunction

endpackage

// File: rtl/hbg_holdoff.sv
module hbg_holdoff #(
  parameter int unsigned HOLD_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  output logic       park
);
  import hbg_pkg::*;

  localparam int CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0] run_q;
  logic          in_mid;

  assign in_mid = lvl_mid(pwm_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n)      run_q <= '0;
    else if (in_mid) run_q <= CW'(sat_step(32'(run_q), HOLD_CYC));
    else             run_q <= '0;
  end

  // the edge that completes HOLD_CYC mid cycles parks the stage
  assign park = in_mid && win_last(32'(run_q), HOLD_CYC);

endmodule

// File: rtl/hbg_watchdog.sv
module hbg_watchdog #(
  parameter int unsigned WD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic waiting,
  input  logic restart,
  output logic expire
);
  import hbg_pkg::*;

  localparam int CW = $clog2(WD_CYC + 1);

  logic [CW-1:0] age_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  age_q <= '0;
    else if (restart || !waiting) age_q <= '0;
    else                          age_q <= CW'(sat_step(32'(age_q), WD_CYC));
  end

  assign expire = waiting && win_last(32'(age_q), WD_CYC);

endmodule

// File: rtl/hbg_sequencer.sv
module hbg_sequencer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  input  logic       kill,
  input  logic       park,
  input  logic       de_on,
  input  logic       zc,
  input  logic       hs_below,
  input  logic       ls_below,
  input  logic       wd_expire,
  output logic       hs_raw,
  output logic       ls_raw,
  output logic       fault_raw,
  output logic       waiting,
  output logic       moving
);
  import hbg_pkg::*;

  seq_st_e st_q, st_d;
  logic    go_hi, go_lo;

  assign go_hi = lvl_high(pwm_lvl);
  assign go_lo = lvl_low(pwm_lvl);

  always_comb begin
    st_d = st_q;
    if (kill || park) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (go_hi)      st_d = ST_HS_WAIT;
          else if (go_lo) st_d = ST_LS_WAIT;
        end
        ST_HS_WAIT: begin
          if (go_lo)          st_d = ST_LS_WAIT;
          else if (ls_below)  st_d = ST_HS_ON;
          else if (wd_expire) st_d = ST_FAULT;
        end
        ST_HS_ON: begin
          if (go_lo) st_d = ST_LS_WAIT;
        end
        ST_LS_WAIT: begin
          if (go_hi)          st_d = ST_HS_WAIT;
          else if (hs_below)  st_d = ST_LS_ON;
          else if (wd_expire) st_d = ST_FAULT;
        end
        ST_LS_ON: begin
          if (go_hi)                     st_d = ST_HS_WAIT;
          else if (de_on && zc && go_lo) st_d = ST_LS_SKIP;
        end
        ST_LS_SKIP: begin
          if (go_hi) st_d = ST_HS_WAIT;
        end
        ST_FAULT: st_d = ST_FAULT;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign hs_raw    = (st_q == ST_HS_ON);
  assign ls_raw    = (st_q == ST_LS_ON);
  assign fault_raw = (st_q == ST_FAULT);
  assign waiting   = (st_q == ST_HS_WAIT) || (st_q == ST_LS_WAIT);
  assign moving    = (st_d != st_q);

endmodule

// File: rtl/hbg_gate_ctrl.sv
module hbg_gate_ctrl #(
  parameter int unsigned HOLD_CYC = 8,
  parameter int unsigned WD_CYC   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_lvl,
  input  logic       dis_n,
  input  logic       skip_sel,
  input  logic       uvlo,
  input  logic       hs_below,
  input  logic       ls_below,
  input  logic       zc,
  output logic       hs_on,
  output logic       ls_on,
  output logic       fault
);

  logic kill;
  logic ts_park;
  logic wd_expire;
  logic waiting;
  logic moving;
  logic hs_raw, ls_raw, fault_raw;

  // asynchronous-path clamp: disable and lockout act without waiting for an edge
  assign kill = uvlo || !dis_n;

  hbg_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_lvl (pwm_lvl),
    .park    (ts_park)
  );

  hbg_watchdog #(.WD_CYC(WD_CYC)) u_wd (
    .clk     (clk),
    .rst_n   (rst_n),
    .waiting (waiting),
    .restart (moving),
    .expire  (wd_expire)
  );

  hbg_sequencer u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_lvl   (pwm_lvl),
    .kill      (kill),
    .park      (ts_park),
    .de_on     (!skip_sel),
    .zc        (zc),
    .hs_below  (hs_below),
    .ls_below  (ls_below),
    .wd_expire (wd_expire),
    .hs_raw    (hs_raw),
    .ls_raw    (ls_raw),
    .fault_raw (fault_raw),
    .waiting   (waiting),
    .moving    (moving)
  );

  assign hs_on = hs_raw && !kill;
  assign ls_on = ls_raw && !kill;
  assign fault = fault_raw;

endmodule

// File: rtl/hbg_gate_ctrl_chk.sv
module hbg_gate_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] pwm_lvl,
  input logic       dis_n,
  input logic       skip_sel,
  input logic       uvlo,
  input logic       hs_below,
  input logic       ls_below,
  input logic       zc,
  input logic       hs_on,
  input logic       ls_on,
  input logic       fault,
  input logic       ts_park,
  input logic       wd_expire
);

  p_hs_after_ls_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> $past(ls_below) && !$past(ls_on));

  p_ls_after_hs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> $past(hs_below) && !$past(hs_on));

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  p_park_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ts_park |=> !hs_on && !ls_on);

  p_disable_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dis_n |-> !hs_on && !ls_on);

  p_zc_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on && !skip_sel && zc && pwm_lvl == 2'b00) |=> !ls_on);

  p_zc_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_on && skip_sel && pwm_lvl == 2'b00 && !ts_park) |=> (ls_on || uvlo || !dis_n));

  p_uvlo_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo |-> !hs_on && !ls_on);

  p_fault_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(wd_expire) && !hs_on && !ls_on);

  p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !hs_on && !ls_on);

endmodule

bind hbg_gate_ctrl hbg_gate_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pwm_lvl   (pwm_lvl),
  .dis_n     (dis_n),
  .skip_sel  (skip_sel),
  .uvlo      (uvlo),
  .hs_below  (hs_below),
  .ls_below  (ls_below),
  .zc        (zc),
  .hs_on     (hs_on),
  .ls_on     (ls_on),
  .fault     (fault),
  .ts_park   (ts_park),
  .wd_expire (wd_expire)
);

// File: tb/hbg_gate_ctrl_tb.sv
module hbg_gate_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pwm_lvl = 2'b01;
  logic       dis_n = 1'b1, skip_sel = 1'b1, uvlo = 1'b0;
  logic       hs_below = 1'b1, ls_below = 1'b1, zc = 1'b0;
  logic       hs_on, ls_on, fault;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hbg_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .dis_n(dis_n),
    .skip_sel(skip_sel), .uvlo(uvlo), .hs_below(hs_below),
    .ls_below(ls_below), .zc(zc), .hs_on(hs_on), .ls_on(ls_on), .fault(fault)
  );

  // vector: pwm[15:14] dis[13] skip[12] uvlo[11] hsb[10] lsb[9] zc[8]
  //         exp_hs[7] exp_ls[6] exp_fault[5] req[4:0]
  localparam int NV = 22;
  localparam logic [15:0] TBL [NV] = '{
    16'b00_1_1_0_1_1_0_0_0_0_00010, // R2 idle -> wait for hs discharge
    16'b00_1_1_0_1_1_0_0_1_0_00010, // R2 low side on
    16'b01_1_1_0_1_0_0_0_0_0_00001, // R1 ls dropped, still charged
    16'b01_1_1_0_1_0_0_0_0_0_00001, // R1 keep waiting
    16'b01_1_1_0_1_1_0_1_0_0_00001, // R1 ls discharged -> hs on
    16'b10_1_1_0_0_1_0_1_0_0_00100, // R4 one mid cycle, no change
    16'b01_1_1_0_0_1_0_1_0_0_00100, // R4 back high
    16'b00_1_1_0_0_1_0_0_0_0_00010, // R2 hs dropped, still charged
    16'b00_1_1_0_1_1_0_0_1_0_00010, // R2 ls on
    16'b00_1_1_0_1_1_1_0_1_0_00111, // R7 zc ignored with skip_sel=1
    16'b00_1_0_0_1_1_0_0_1_0_00110, // R6 emulation armed
    16'b00_1_0_0_1_1_1_0_0_0_00110, // R6 zc cuts low side
    16'b00_1_0_0_1_1_0_0_0_0_00110, // R6 stays off
    16'b01_1_0_0_1_1_0_0_0_0_00110, // R6 next high restarts sequence
    16'b01_1_0_0_1_1_0_1_0_0_00001, // R1 hs on
    16'b01_0_1_0_1_1_0_0_0_0_00101, // R5 disabled
    16'b01_1_1_0_1_1_0_0_0_0_01001, // R9 resume via wait
    16'b01_1_1_0_1_1_0_1_0_0_01001, // R9 hs on
    16'b01_1_1_1_1_1_0_0_0_0_01000, // R8 lockout
    16'b10_1_1_0_1_1_0_0_0_0_01001, // R9 mid keeps idle
    16'b00_1_1_0_1_1_0_0_0_0_01001, // R9 low -> wait
    16'b00_1_1_0_1_1_0_0_1_0_01001  // R9 ls on
  };

  task automatic chk(input string req, input logic got, input logic exp, input string what);
    n_run++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #1000000;
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin : main
    string rq;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11", hs_on, 1'b0, "hs_on in reset");
    chk("R11", ls_on, 1'b0, "ls_on in reset");
    rst_n = 1'b1;
    pwm_lvl = 2'b10;
    step();
    chk("R11", hs_on | ls_on, 1'b0, "gates after reset");
    chk("R11", fault, 1'b0, "fault after reset");

    for (int i = 0; i < NV; i++) begin
      pwm_lvl  = TBL[i][15:14];
      dis_n    = TBL[i][13];
      skip_sel = TBL[i][12];
      uvlo     = TBL[i][11];
      hs_below = TBL[i][10];
      ls_below = TBL[i][9];
      zc       = TBL[i][8];
      step();
      rq = $sformatf("R%0d", TBL[i][4:0]);
      chk(rq, hs_on, TBL[i][7], $sformatf("vec %0d hs_on", i));
      chk(rq, ls_on, TBL[i][6], $sformatf("vec %0d ls_on", i));
      chk(rq, fault, TBL[i][5], $sformatf("vec %0d fault", i));
    end

    // R8 lockout clamps between edges; reach hs on first
    skip_sel = 1'b1; hs_below = 1'b1; ls_below = 1'b1; pwm_lvl = 2'b01;
    step(); step();
    chk("R1", hs_on, 1'b1, "hs on before uvlo");
    #1 uvlo = 1'b1;
    #0.5;
    chk("R8", hs_on, 1'b0, "hs clamp same cycle");
    step();
    uvlo = 1'b0;
    step(); step();
    chk("R9", hs_on, 1'b1, "hs back after lockout");

    // R4 seven mid edges keep hs on, eight park it
    pwm_lvl = 2'b10;
    repeat (7) step();
    chk("R4", hs_on, 1'b1, "hs after 7 mid edges");
    pwm_lvl = 2'b01;
    step();
    pwm_lvl = 2'b10;
    repeat (7) step();
    chk("R4", hs_on, 1'b1, "hs after restarted 7 mid edges");
    step();
    chk("R4", hs_on, 1'b0, "hs after 8 mid edges");
    pwm_lvl = 2'b01;
    step();
    chk("R9", hs_on, 1'b0, "first edge after park");
    step();
    chk("R9", hs_on, 1'b1, "second edge after park");

    // R10 watchdog: command low, hs never reported discharged
    pwm_lvl = 2'b00; hs_below = 1'b0;
    repeat (16) step();
    chk("R10", fault, 1'b0, "fault after 16 edges");
    chk("R10", ls_on, 1'b0, "ls while waiting");
    step();
    chk("R10", fault, 1'b1, "fault after 17 edges");
    hs_below = 1'b1;
    repeat (3) step();
    chk("R10", fault, 1'b1, "fault held");
    chk("R10", ls_on, 1'b0, "ls held off in fault");
    dis_n = 1'b0;
    step();
    chk("R10", fault, 1'b0, "fault cleared by disable");
    dis_n = 1'b1;

    // R3 / R8 random phase
    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      pwm_lvl  = r[1:0];
      dis_n    = r[4:2] != 3'b000;
      skip_sel = r[5];
      uvlo     = r[10:6] == 5'b00000;
      hs_below = r[12] | r[13];
      ls_below = r[14] | r[15];
      zc       = r[16];
      step();
      chk("R3", hs_on & ls_on, 1'b0, "overlap");
      if (uvlo)   chk("R8", hs_on | ls_on, 1'b0, "random uvlo");
      if (!dis_n) chk("R5", hs_on | ls_on, 1'b0, "random disable");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule